// File: doc/BRIEF.md
# Flash Embedded-Operation Status Register

This block holds the 16-bit status word of a NOR flash device. The embedded program/erase engine reports to it through single-cycle strobes: an operation starts, an operation finishes with its result flags, a suspension is acknowledged, and a continuity pattern is seen. The host command decoder sends it decoded commands: clear status, soft reset, the two suspend commands, the two resume commands and read status. It also sends program requests that target a sector.

The host reads status in two steps. First it issues a read-status command that names a sector. Its next bus access must then be a read of that same sector. Idle cycles may come between the two. That read returns the status word. Any other read returns the array data presented at `array_data`. Read data is registered and appears one cycle after the read strobe, qualified by `rd_valid`.

Top module: `esr_status_top`

## Requirements
- R1: After a cold reset (`rst_n` low) or a warm reset (`warm_rst` high), the status word is 0x0080: bit 7 is 1 and every other bit is 0.
- R2: An engine start clears bit 7. An engine done sets bit 7 and records the results of the operation that ran. For a program it writes bit 4 (failed) and bit 3 (write-buffer aborted). For an erase it writes bit 5 (failed). Either kind writes bit 1 (locked-sector error). A result bit of the other kind keeps its value.
- R3: A status read while bit 7 is 0 returns 0x0000, because bits 6..0 are masked. Bits 15..8 always read as 0.
- R4: Command code 0 (clear status) clears bits 5, 4, 3 and 1 and leaves bits 7, 6, 2 and 0 unchanged.
- R5: Command code 1 (soft reset) clears the same bits 5, 4, 3 and 1.
- R6: A suspend command only has effect while the engine is busy with the matching kind of operation: code 5 for an erase, code 6 for a program. After it, bit 7 stays 0 until the engine acknowledges. The acknowledge then sets bit 6 (erase) or bit 2 (program) and sets bit 7.
- R7: Code 2 (erase resume) while bit 6 is set clears bit 6 and clears bit 7. Code 3 (program resume) while bit 2 is set clears bit 2 and clears bit 7. A resume while not suspended has no effect.
- R8: A program request to the sector whose erase is suspended sets bit 4. A program request to any other sector does not change the status.
- R9: A continuity strobe sets bit 0. Only a cold or warm reset clears bit 0.
- R10: Code 4 (read status) followed by a read of the same sector, with no other command or read in between, returns the status word. A read of another sector, a read after an intervening access, or a read without a preceding code 4 returns `array_data`. Read data appears one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, active low, asynchronous |
| warm_rst | input | 1 | Warm reset, synchronous, active high |
| eng_start | input | 1 | Engine begins an operation |
| eng_start_erase | input | 1 | With eng_start: 1 = erase, 0 = program |
| eng_sector | input | SECTOR_W | With eng_start: target sector |
| eng_done | input | 1 | Engine finished the current operation |
| eng_fail | input | 1 | With eng_done: operation failed |
| eng_wb_abort | input | 1 | With eng_done: write-buffer program aborted |
| eng_lock_err | input | 1 | With eng_done: target sector was locked |
| eng_susp_ack | input | 1 | Engine has reached its suspended state |
| cont_hit | input | 1 | Continuity pattern detected |
| cmd_valid | input | 1 | Decoded host command strobe |
| cmd_code | input | 3 | Command code (0..6, see requirements) |
| cmd_sector | input | SECTOR_W | Sector named by the command |
| prog_req | input | 1 | Host program request |
| prog_sector | input | SECTOR_W | Sector of the program request |
| rd_en | input | 1 | Host read strobe |
| rd_sector | input | SECTOR_W | Sector of the host read |
| array_data | input | DATA_W | Array data for non-status reads |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |

## Verification
The hardest state to reach is a program request aimed at the sector of a suspended erase. To get there, an erase must start, an erase-suspend command must arrive while it is busy, and the engine must acknowledge. Only then does a program request to that exact sector mean anything. The bench builds this chain directed, once with a matching sector and once with a non-matching one. It then runs a seeded random mix of engine strobes and commands over a small range of sectors, so that suspend, acknowledge, resume and conflicting programs line up repeatedly. A bench-side model tracks the expected word.

// File: rtl/esr_pkg.sv
package esr_pkg;

   typedef enum logic [2:0] {
      CMD_CLR_STAT   = 3'd0,
      CMD_SOFT_RST   = 3'd1,
      CMD_ERS_RESUME = 3'd2,
      CMD_PGM_RESUME = 3'd3,
      CMD_RD_STAT    = 3'd4,
      CMD_ERS_SUSP   = 3'd5,
      CMD_PGM_SUSP   = 3'd6,
      CMD_NONE       = 3'd7
   } esr_cmd_e;

   // Field order follows the status word: ready is bit 7, cont is bit 0.
   typedef struct packed {
      logic ready;
      logic esusp;
      logic efail;
      logic pfail;
      logic wbabort;
      logic psusp;
      logic lockerr;
      logic cont;
   } esr_bits_t;

   localparam int STAT_LOW_W = 8;
   localparam esr_bits_t ESR_RESET = 8'h80;

endpackage

// File: rtl/esr_op_track.sv
module esr_op_track
   import esr_pkg::*;
#(
   parameter int SECTOR_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                warm_rst,
   input  logic                eng_start,
   input  logic                eng_start_erase,
   input  logic [SECTOR_W-1:0] eng_sector,
   input  logic                eng_done,
   input  logic                eng_susp_ack,
   input  logic                cmd_ers_susp,
   input  logic                cmd_pgm_susp,
   input  logic                cmd_ers_res,
   input  logic                cmd_pgm_res,
   input  logic                ready_q,
   input  logic                esusp_q,
   input  logic                psusp_q,
   output logic                cur_erase,
   output logic [SECTOR_W-1:0] susp_sector,
   output logic                susp_pend,
   output logic                susp_grant,
   output logic                ers_res_ok,
   output logic                pgm_res_ok
);

   logic [SECTOR_W-1:0] cur_sector;

   assign susp_grant = eng_susp_ack && susp_pend;
   assign ers_res_ok = cmd_ers_res && esusp_q;
   assign pgm_res_ok = cmd_pgm_res && psusp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_erase   <= 1'b0;
         cur_sector  <= '0;
         susp_sector <= '0;
         susp_pend   <= 1'b0;
      end else if (warm_rst) begin
         cur_erase   <= 1'b0;
         cur_sector  <= '0;
         susp_sector <= '0;
         susp_pend   <= 1'b0;
      end else begin
         if (eng_start) begin
            cur_erase  <= eng_start_erase;
            cur_sector <= eng_sector;
            susp_pend  <= 1'b0;
         end
         if (eng_done) susp_pend <= 1'b0;
         if (cmd_ers_susp && !ready_q && cur_erase) susp_pend <= 1'b1;
         if (cmd_pgm_susp && !ready_q && !cur_erase) susp_pend <= 1'b1;
         if (susp_grant) begin
            susp_pend <= 1'b0;
            if (cur_erase) susp_sector <= cur_sector;
         end
         if (ers_res_ok) begin
            cur_erase  <= 1'b1;
            cur_sector <= susp_sector;
         end
         if (pgm_res_ok) cur_erase <= 1'b0;
      end
   end

   // R6: a granted suspension leaves nothing pending
   p_grant_clears_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
      susp_grant && !cmd_ers_susp && !cmd_pgm_susp |=> !susp_pend);

   // R7: erase resume makes the suspended sector current again
   p_resume_restores_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ers_res_ok && !eng_start && !warm_rst |=> cur_erase && cur_sector == $past(susp_sector));

endmodule

// File: rtl/esr_bits.sv
module esr_bits
   import esr_pkg::*;
#(
   parameter int SECTOR_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                warm_rst,
   input  logic                eng_start,
   input  logic                eng_done,
   input  logic                eng_fail,
   input  logic                eng_wb_abort,
   input  logic                eng_lock_err,
   input  logic                cur_erase,
   input  logic                susp_grant,
   input  logic                ers_res_ok,
   input  logic                pgm_res_ok,
   input  logic                prog_req,
   input  logic [SECTOR_W-1:0] prog_sector,
   input  logic [SECTOR_W-1:0] susp_sector,
   input  logic                cont_hit,
   input  logic                clr_results,
   output esr_bits_t           st
);

   logic conflict;
   assign conflict = prog_req && st.esusp && (prog_sector == susp_sector);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ESR_RESET;
      end else if (warm_rst) begin
         st <= ESR_RESET;
      end else begin
         if (eng_done) begin
            st.ready   <= 1'b1;
            st.lockerr <= eng_lock_err;
            if (cur_erase) begin
               st.efail <= eng_fail;
            end else begin
               st.pfail   <= eng_fail;
               st.wbabort <= eng_wb_abort;
            end
         end
         if (eng_start) st.ready <= 1'b0;
         if (susp_grant) begin
            st.ready <= 1'b1;
            if (cur_erase) st.esusp <= 1'b1;
            else           st.psusp <= 1'b1;
         end
         if (ers_res_ok) begin
            st.esusp <= 1'b0;
            st.ready <= 1'b0;
         end
         if (pgm_res_ok) begin
            st.psusp <= 1'b0;
            st.ready <= 1'b0;
         end
         if (conflict) st.pfail <= 1'b1;
         if (cont_hit) st.cont <= 1'b1;
         if (clr_results) begin
            st.efail   <= 1'b0;
            st.pfail   <= 1'b0;
            st.wbabort <= 1'b0;
            st.lockerr <= 1'b0;
         end
      end
   end

   p_warm_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      warm_rst |=> st == ESR_RESET);

   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start && !eng_done && !susp_grant && !warm_rst |=> !st.ready);

   p_clear_results_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_results |=> !st.efail && !st.pfail && !st.wbabort && !st.lockerr);

   // R5 shares the clear path; the kept bits must not move
   p_clear_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_results && !warm_rst && !eng_start && !eng_done && !susp_grant && !ers_res_ok
      && !pgm_res_ok && !cont_hit |=> $stable(st.ready) && $stable(st.esusp) && $stable(st.psusp));

   p_conflict_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
      conflict && !clr_results && !warm_rst |=> st.pfail);

   p_cont_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      st.cont && !warm_rst |=> st.cont);

endmodule

// File: rtl/esr_read_port.sv
module esr_read_port
   import esr_pkg::*;
#(
   parameter int SECTOR_W        = 8,
   parameter int DATA_W          = 16,
   parameter bit MASK_WHILE_BUSY = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                warm_rst,
   input  logic                cmd_valid,
   input  logic                cmd_rd_stat,
   input  logic [SECTOR_W-1:0] cmd_sector,
   input  logic                rd_en,
   input  logic [SECTOR_W-1:0] rd_sector,
   input  logic [DATA_W-1:0]   array_data,
   input  esr_bits_t           st,
   output logic                rd_valid,
   output logic [DATA_W-1:0]   rd_data
);

   localparam int RSVD_W = DATA_W - STAT_LOW_W;

   logic                armed;
   logic [SECTOR_W-1:0] arm_sector;
   logic                hit;
   logic [DATA_W-1:0]   stat_word;

   assign hit = rd_en && armed && (rd_sector == arm_sector);

   generate
      if (MASK_WHILE_BUSY) begin : g_mask
         assign stat_word = st.ready ? {{RSVD_W{1'b0}}, st} : '0;

         p_busy_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
            hit && !st.ready && !warm_rst |=> rd_data == '0);
      end else begin : g_raw
         assign stat_word = {{RSVD_W{1'b0}}, st};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed      <= 1'b0;
         arm_sector <= '0;
         rd_valid   <= 1'b0;
         rd_data    <= '0;
      end else if (warm_rst) begin
         armed      <= 1'b0;
         arm_sector <= '0;
         rd_valid   <= 1'b0;
         rd_data    <= '0;
      end else begin
         if (cmd_valid || rd_en) armed <= cmd_rd_stat;
         if (cmd_rd_stat) arm_sector <= cmd_sector;
         rd_valid <= rd_en;
         if (rd_en) rd_data <= hit ? stat_word : array_data;
      end
   end

   p_array_path_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !armed && !warm_rst |=> rd_data == $past(array_data));

   p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit && !warm_rst |=> rd_data[DATA_W-1:STAT_LOW_W] == '0);

   p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !warm_rst |=> rd_valid == $past(rd_en));

endmodule

// File: rtl/esr_status_top.sv
module esr_status_top
   import esr_pkg::*;
#(
   parameter int SECTOR_W        = 8,
   parameter int DATA_W          = 16,
   parameter bit MASK_WHILE_BUSY = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                warm_rst,
   input  logic                eng_start,
   input  logic                eng_start_erase,
   input  logic [SECTOR_W-1:0] eng_sector,
   input  logic                eng_done,
   input  logic                eng_fail,
   input  logic                eng_wb_abort,
   input  logic                eng_lock_err,
   input  logic                eng_susp_ack,
   input  logic                cont_hit,
   input  logic                cmd_valid,
   input  logic [2:0]          cmd_code,
   input  logic [SECTOR_W-1:0] cmd_sector,
   input  logic                prog_req,
   input  logic [SECTOR_W-1:0] prog_sector,
   input  logic                rd_en,
   input  logic [SECTOR_W-1:0] rd_sector,
   input  logic [DATA_W-1:0]   array_data,
   output logic                rd_valid,
   output logic [DATA_W-1:0]   rd_data
);

   generate
      if (DATA_W < 16) begin : g_bad_data_w
         $error("esr_status_top: DATA_W must be at least 16");
      end
      if (SECTOR_W < 1) begin : g_bad_sector_w
         $error("esr_status_top: SECTOR_W must be at least 1");
      end
   endgenerate

   esr_cmd_e  cmd;
   logic      c_clr, c_srst, c_eres, c_pres, c_rd, c_esus, c_psus;
   esr_bits_t st;
   logic      cur_erase, susp_pend, susp_grant, ers_res_ok, pgm_res_ok;
   logic [SECTOR_W-1:0] susp_sector;

   assign cmd    = esr_cmd_e'(cmd_code);
   assign c_clr  = cmd_valid && (cmd == CMD_CLR_STAT);
   assign c_srst = cmd_valid && (cmd == CMD_SOFT_RST);
   assign c_eres = cmd_valid && (cmd == CMD_ERS_RESUME);
   assign c_pres = cmd_valid && (cmd == CMD_PGM_RESUME);
   assign c_rd   = cmd_valid && (cmd == CMD_RD_STAT);
   assign c_esus = cmd_valid && (cmd == CMD_ERS_SUSP);
   assign c_psus = cmd_valid && (cmd == CMD_PGM_SUSP);

   esr_op_track #(.SECTOR_W(SECTOR_W)) u_track (
      .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
      .eng_start(eng_start), .eng_start_erase(eng_start_erase), .eng_sector(eng_sector),
      .eng_done(eng_done), .eng_susp_ack(eng_susp_ack),
      .cmd_ers_susp(c_esus), .cmd_pgm_susp(c_psus),
      .cmd_ers_res(c_eres), .cmd_pgm_res(c_pres),
      .ready_q(st.ready), .esusp_q(st.esusp), .psusp_q(st.psusp),
      .cur_erase(cur_erase), .susp_sector(susp_sector), .susp_pend(susp_pend),
      .susp_grant(susp_grant), .ers_res_ok(ers_res_ok), .pgm_res_ok(pgm_res_ok)
   );

   esr_bits #(.SECTOR_W(SECTOR_W)) u_bits (
      .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
      .eng_start(eng_start), .eng_done(eng_done), .eng_fail(eng_fail),
      .eng_wb_abort(eng_wb_abort), .eng_lock_err(eng_lock_err),
      .cur_erase(cur_erase), .susp_grant(susp_grant),
      .ers_res_ok(ers_res_ok), .pgm_res_ok(pgm_res_ok),
      .prog_req(prog_req), .prog_sector(prog_sector), .susp_sector(susp_sector),
      .cont_hit(cont_hit), .clr_results(c_clr || c_srst), .st(st)
   );

   esr_read_port #(.SECTOR_W(SECTOR_W), .DATA_W(DATA_W), .MASK_WHILE_BUSY(MASK_WHILE_BUSY)) u_rd (
      .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
      .cmd_valid(cmd_valid), .cmd_rd_stat(c_rd), .cmd_sector(cmd_sector),
      .rd_en(rd_en), .rd_sector(rd_sector), .array_data(array_data),
      .st(st), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   p_susp_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      susp_pend && !eng_susp_ack && !eng_done && !warm_rst |=> !st.ready);

   p_cmd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({c_clr, c_srst, c_eres, c_pres, c_rd, c_esus, c_psus}));

endmodule

// File: tb/esr_status_top_tb.sv
module esr_status_top_tb;

   localparam int SW = 8;
   localparam int DW = 16;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, warm_rst, eng_start, eng_start_erase, eng_done, eng_fail;
   logic eng_wb_abort, eng_lock_err, eng_susp_ack, cont_hit, cmd_valid, prog_req, rd_en;
   logic [2:0]    cmd_code;
   logic [SW-1:0] eng_sector, cmd_sector, prog_sector, rd_sector;
   logic [DW-1:0] array_data, rd_data;
   logic          rd_valid;

   esr_status_top #(.SECTOR_W(SW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
      .eng_start(eng_start), .eng_start_erase(eng_start_erase), .eng_sector(eng_sector),
      .eng_done(eng_done), .eng_fail(eng_fail), .eng_wb_abort(eng_wb_abort),
      .eng_lock_err(eng_lock_err), .eng_susp_ack(eng_susp_ack), .cont_hit(cont_hit),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_sector(cmd_sector),
      .prog_req(prog_req), .prog_sector(prog_sector),
      .rd_en(rd_en), .rd_sector(rd_sector), .array_data(array_data),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // reference model
   bit m_ready, m_esusp, m_efail, m_pfail, m_wba, m_psusp, m_lock, m_cont;
   bit m_cur_erase, m_pend;
   int m_cur_sec, m_susp_sec;

   function automatic logic [15:0] exp_word();
      if (!m_ready) return 16'h0000;
      return {8'h00, m_ready, m_esusp, m_efail, m_pfail, m_wba, m_psusp, m_lock, m_cont};
   endfunction

   task automatic model_reset();
      m_ready = 1; m_esusp = 0; m_efail = 0; m_pfail = 0; m_wba = 0; m_psusp = 0;
      m_lock = 0; m_cont = 0; m_cur_erase = 0; m_pend = 0; m_cur_sec = 0; m_susp_sec = 0;
   endtask

   task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clear_inputs();
      warm_rst = 0; eng_start = 0; eng_start_erase = 0; eng_sector = '0; eng_done = 0;
      eng_fail = 0; eng_wb_abort = 0; eng_lock_err = 0; eng_susp_ack = 0; cont_hit = 0;
      cmd_valid = 0; cmd_code = 3'd7; cmd_sector = '0; prog_req = 0; prog_sector = '0;
      rd_en = 0; rd_sector = '0;
   endtask

   // every task starts and ends at a falling edge
   task automatic ev_start(input bit erase, input int sec);
      eng_start = 1; eng_start_erase = erase; eng_sector = SW'(sec);
      @(negedge clk); clear_inputs();
      m_ready = 0; m_cur_erase = erase; m_cur_sec = sec; m_pend = 0;
   endtask

   task automatic ev_done(input bit fail, input bit abrt, input bit lck);
      eng_done = 1; eng_fail = fail; eng_wb_abort = abrt; eng_lock_err = lck;
      @(negedge clk); clear_inputs();
      m_ready = 1; m_lock = lck; m_pend = 0;
      if (m_cur_erase) m_efail = fail;
      else begin m_pfail = fail; m_wba = abrt; end
   endtask

   task automatic ev_ack();
      eng_susp_ack = 1;
      @(negedge clk); clear_inputs();
      if (m_pend) begin
         m_pend = 0; m_ready = 1;
         if (m_cur_erase) begin m_esusp = 1; m_susp_sec = m_cur_sec; end
         else m_psusp = 1;
      end
   endtask

   task automatic ev_cmd(input int code, input int sec);
      cmd_valid = 1; cmd_code = 3'(code); cmd_sector = SW'(sec);
      @(negedge clk); clear_inputs();
      case (code)
         0, 1: begin m_efail = 0; m_pfail = 0; m_wba = 0; m_lock = 0; end
         2: if (m_esusp) begin m_esusp = 0; m_ready = 0; m_cur_erase = 1; m_cur_sec = m_susp_sec; end
         3: if (m_psusp) begin m_psusp = 0; m_ready = 0; m_cur_erase = 0; end
         5: if (!m_ready && m_cur_erase) m_pend = 1;
         6: if (!m_ready && !m_cur_erase) m_pend = 1;
         default: ;
      endcase
   endtask

   task automatic ev_prog(input int sec);
      prog_req = 1; prog_sector = SW'(sec);
      @(negedge clk); clear_inputs();
      if (m_esusp && sec == m_susp_sec) m_pfail = 1;
   endtask

   task automatic ev_cont();
      cont_hit = 1;
      @(negedge clk); clear_inputs();
      m_cont = 1;
   endtask

   task automatic ev_warm();
      warm_rst = 1;
      @(negedge clk); clear_inputs();
      model_reset();
   endtask

   task automatic do_read(input int sec, input logic [DW-1:0] arr);
      rd_en = 1; rd_sector = SW'(sec); array_data = arr;
      @(negedge clk); clear_inputs();
   endtask

   task automatic read_status(input int sec, input string tag);
      logic [DW-1:0] junk;
      junk = DW'($urandom);
      cmd_valid = 1; cmd_code = 3'd4; cmd_sector = SW'(sec);
      @(negedge clk); clear_inputs();
      do_read(sec, junk);
      check(rd_valid, 1'b1, {tag, " rd_valid"});
      check(rd_data, exp_word(), tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned seed_dummy;
      clear_inputs();
      array_data = '0;
      rst_n = 0;
      model_reset();
      seed_dummy = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      check(rd_valid, 1'b0, "R1 reset rd_valid");
      check(rd_data, '0, "R1 reset rd_data");
      rst_n = 1;
      @(negedge clk);
      read_status(0, "R1 cold reset word 0x0080");

      // R2 / R3 program lifecycle
      ev_start(0, 2);
      read_status(2, "R3 busy read masked");
      ev_done(1, 1, 1);
      read_status(2, "R2 program results 0x9A");
      ev_start(1, 4);
      ev_done(1, 0, 0);
      read_status(4, "R2 erase result keeps program bits");

      // R9 and R4
      ev_cont();
      read_status(1, "R9 continuity set");
      ev_cmd(0, 0);
      read_status(1, "R4 clear keeps ready/cont");

      // R5
      ev_start(0, 1);
      ev_done(1, 0, 1);
      ev_cmd(1, 0);
      read_status(1, "R5 soft reset clears results");

      // R6 erase suspend
      ev_start(1, 5);
      ev_cmd(5, 5);
      repeat (3) @(negedge clk);
      read_status(5, "R6 waiting for ack still busy");
      ev_ack();
      read_status(5, "R6 erase suspended 0xC1");

      // R8
      ev_prog(3);
      read_status(5, "R8 other sector no effect");
      ev_prog(5);
      read_status(5, "R8 suspended sector program fails");
      ev_cmd(0, 0);

      // R7
      ev_cmd(3, 0);
      read_status(5, "R7 program resume without suspend ignored");
      ev_cmd(2, 0);
      read_status(5, "R7 erase resume busy");
      ev_done(0, 0, 0);
      read_status(5, "R7 erase resume done");
      ev_start(0, 6);
      ev_cmd(5, 0);
      ev_ack();
      read_status(6, "R6 erase suspend ignored for program");
      ev_cmd(6, 0);
      ev_ack();
      read_status(6, "R6 program suspended bit 2");
      ev_cmd(3, 0);
      read_status(6, "R7 program resume busy");
      ev_done(0, 0, 0);
      read_status(6, "R7 program resume done");

      // R10 two-cycle access
      ev_cmd(4, 2);
      do_read(3, 16'hA5C3);
      check(rd_data, 16'hA5C3, "R10 other sector gives array");
      ev_cmd(4, 2);
      ev_cmd(0, 0);
      do_read(2, 16'h1234);
      check(rd_data, 16'h1234, "R10 intervening command gives array");
      do_read(2, 16'hBEEF);
      check(rd_data, 16'hBEEF, "R10 plain read gives array");
      ev_cmd(4, 7);
      repeat (2) @(negedge clk);
      do_read(7, 16'hFFFF);
      check(rd_data, exp_word(), "R10 status after idle cycles");
      do_read(7, 16'h0F0F);
      check(rd_data, 16'h0F0F, "R10 second read gives array");

      // R1 / R9 warm reset
      ev_warm();
      read_status(0, "R1 R9 warm reset word 0x0080");

      // random mix
      for (int i = 0; i < 400; i++) begin
         int k;
         int s;
         k = int'($urandom_range(0, 9));
         s = int'($urandom_range(0, 3));
         case (k)
            0: ev_start(1'($urandom_range(0, 1)), s);
            1, 2: ev_done(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            3: ev_ack();
            4: ev_cmd(5 + int'($urandom_range(0, 1)), s);
            5: ev_cmd(2 + int'($urandom_range(0, 1)), s);
            6: ev_prog(s);
            7: ev_cmd(int'($urandom_range(0, 1)), s);
            8: if ($urandom_range(0, 7) == 0) ev_cont(); else ev_start(1, s);
            default: if ($urandom_range(0, 15) == 0) ev_warm(); else ev_cmd(5, s);
         endcase
         read_status(s, "R2 R4 R6 R7 R8 random mix");
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule